// File: doc/BRIEF.md
# Trap Return State Restorer

This block carries out the two trap-return operations of a windowed processor core. When a command strobe arrives it takes the state that was saved on trap entry at the current trap level: the saved program counter, the saved next program counter, the packed trap-state word and, when hypervisor support is built in, the saved hypervisor state. From these it rebuilds the architectural context in a single clock edge. That context is the fetch pair (PC and NPC), the extended and 32-bit condition codes, the address-space identifier, the masked processor state, the register window pointer, the global-register level and the hypervisor state. It also lowers the trap level by one.

The two operations differ only in where execution resumes. The "done" form skips the trapped instruction, so it resumes at the saved NPC and the instruction that follows it. The "retry" form re-executes the trapped instruction, so it resumes at the saved PC and NPC. The window pointer field of the trap-state word uses the mirrored numbering, so it is reduced modulo the window count and flipped before it is applied. A command issued at trap level zero is refused with an illegal-instruction pulse, and every output keeps its value. The saved-state stack is outside the block and arrives as input ports. The global-register bank swap is reduced to the new level output, which a register-file neighbour uses.

Top module: `trap_return_unit`

## Requirements
- R1: After reset every restored output, the trap level, `done_o` and `illegal_o` are zero.
- R2: A "done" command (`cmd_retry_i`=0) at a nonzero trap level makes `pc_o` equal the saved NPC and `npc_o` equal the saved NPC plus 4 (modulo 2^PC_W), with `done_o` high for exactly the cycle after the strobe.
- R3: A "retry" command (`cmd_retry_i`=1) at a nonzero trap level makes `pc_o` equal the saved PC and `npc_o` equal the saved NPC, with `done_o` high the cycle after the strobe.
- R4: Trap-state bits 39:36 load `xcc_o` and bits 35:32 load `icc_o`.
- R5: Trap-state bits 31:24 load `asi_o`.
- R6: `pstate_o` loads trap-state bits 19:8 ANDed with 0xF3F. Bits 7:6 of the field are always restored as zero.
- R7: `cwp_o` loads NWIN-1 minus (trap-state bits 7:0 modulo NWIN).
- R8: With HV_EN=1, `gl_o` loads trap-state bits 42:40 and `hpstate_o` loads `saved_hstate_i`. Trap-state bits 47:43 and 23:20 affect no output.
- R9: A legal command sets `tl_o` to `cur_tl_i` minus one.
- R10: A command with `cur_tl_i`=0 pulses `illegal_o` for one cycle, leaves `done_o` low and changes none of the restored outputs or `tl_o`.
- R11: In a cycle without `cmd_valid_i`, no output changes and both pulses are low the following cycle. Commands on consecutive cycles are each carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Trap-return command strobe |
| cmd_retry_i | input | 1 | 1 = retry, 0 = done |
| cur_tl_i | input | TL_W | Current trap level |
| saved_pc_i | input | PC_W | Saved PC at the current level |
| saved_npc_i | input | PC_W | Saved NPC at the current level |
| saved_state_i | input | 48 | Packed trap-state word at the current level |
| saved_hstate_i | input | HPS_W | Saved hypervisor state at the current level |
| pc_o | output | PC_W | Restored PC |
| npc_o | output | PC_W | Restored NPC |
| xcc_o | output | 4 | Extended condition codes |
| icc_o | output | 4 | 32-bit condition codes |
| asi_o | output | 8 | Address-space identifier |
| pstate_o | output | 12 | Masked processor state |
| cwp_o | output | CWP_W | Window pointer in internal numbering |
| gl_o | output | 3 | Global-register level / bank index |
| hpstate_o | output | HPS_W | Hypervisor state |
| tl_o | output | TL_W | Trap level after the return |
| done_o | output | 1 | Restore completed pulse |
| illegal_o | output | 1 | Illegal-instruction pulse |

## Verification
Every restored field is a register that loads once per legal command. A wrong slice, mask or mirror shows at the ports in the first cycle after the strobe, as a field that disagrees with the trap-state word. An error in the trap-level guard shows in that same cycle, either as a `done_o` where `illegal_o` was due or as outputs that move after a refused command. Held state that leaks shows up during idle cycles, when an output changes while no strobe is present.

// File: rtl/trp_pkg.sv
package trp_pkg;
   localparam int TS_W       = 48;
   localparam int GL_W       = 3;
   localparam int CC_W       = 4;
   localparam int ASI_W      = 8;
   localparam int PST_W      = 12;
   localparam int WRAW_W     = 8;
   localparam int GL_LSB     = 40;
   localparam int XCC_LSB    = 36;
   localparam int ICC_LSB    = 32;
   localparam int ASI_LSB    = 24;
   localparam int PST_LSB    = 8;
   localparam int WRAW_LSB   = 0;
   localparam logic [PST_W-1:0] PST_KEEP = 12'hF3F;

   typedef struct packed {
      logic [GL_W-1:0]   gl;
      logic [CC_W-1:0]   xcc;
      logic [CC_W-1:0]   icc;
      logic [ASI_W-1:0]  asi;
      logic [PST_W-1:0]  pst;
      logic [WRAW_W-1:0] wraw;
   } ts_fields_t;

   function automatic ts_fields_t split_ts(input logic [TS_W-1:0] ts);
      ts_fields_t f;
      f.gl   = ts[GL_LSB   +: GL_W];
      f.xcc  = ts[XCC_LSB  +: CC_W];
      f.icc  = ts[ICC_LSB  +: CC_W];
      f.asi  = ts[ASI_LSB  +: ASI_W];
      f.pst  = ts[PST_LSB  +: PST_W] & PST_KEEP;
      f.wraw = ts[WRAW_LSB +: WRAW_W];
      return f;
   endfunction
endpackage

// File: rtl/trp_pc_sel.sv
module trp_pc_sel #(
   parameter int PC_W       = 64,
   parameter int INSN_BYTES = 4
) (
   input  logic            retry_i,
   input  logic [PC_W-1:0] tpc_i,
   input  logic [PC_W-1:0] tnpc_i,
   output logic [PC_W-1:0] pc_o,
   output logic [PC_W-1:0] npc_o
);
   always_comb begin
      if (retry_i) begin
         pc_o  = tpc_i;
         npc_o = tnpc_i;
      end else begin
         pc_o  = tnpc_i;
         npc_o = tnpc_i + PC_W'(INSN_BYTES);
      end
   end
endmodule

// File: rtl/trp_cwp_map.sv
module trp_cwp_map #(
   parameter int NWIN  = 8,
   parameter int CWP_W = $clog2(NWIN)
) (
   input  logic [7:0]       raw_i,
   output logic [CWP_W-1:0] cwp_o
);
   localparam bit POW2 = ((NWIN & (NWIN - 1)) == 0);

   generate
      if (POW2) begin : g_pow2
         logic [7:0] unused_hi;
         assign unused_hi = raw_i;
         assign cwp_o = ~raw_i[CWP_W-1:0];
      end else begin : g_mod
         logic [7:0] rem;
         assign rem   = raw_i % 8'(NWIN);
         assign cwp_o = CWP_W'(NWIN - 1) - rem[CWP_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/trp_hv_sel.sv
module trp_hv_sel #(
   parameter bit HV_EN = 1'b1,
   parameter int GL_W  = 3,
   parameter int HPS_W = 12
) (
   input  logic [GL_W-1:0]  cur_gl_i,
   input  logic [HPS_W-1:0] cur_hps_i,
   input  logic [GL_W-1:0]  new_gl_i,
   input  logic [HPS_W-1:0] new_hps_i,
   output logic [GL_W-1:0]  gl_o,
   output logic [HPS_W-1:0] hps_o
);
   generate
      if (HV_EN) begin : g_hv
         logic unused_cur;
         assign unused_cur = ^{cur_gl_i, cur_hps_i};
         assign gl_o  = new_gl_i;
         assign hps_o = new_hps_i;
      end else begin : g_nohv
         logic unused_new;
         assign unused_new = ^{new_gl_i, new_hps_i};
         assign gl_o  = cur_gl_i;
         assign hps_o = cur_hps_i;
      end
   endgenerate
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
   import trp_pkg::*;
#(
   parameter int PC_W       = 64,
   parameter int NWIN       = 8,
   parameter int TL_W       = 3,
   parameter int HPS_W      = 12,
   parameter int INSN_BYTES = 4,
   parameter bit HV_EN      = 1'b1,
   localparam int CWP_W     = $clog2(NWIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid_i,
   input  logic              cmd_retry_i,
   input  logic [TL_W-1:0]   cur_tl_i,
   input  logic [PC_W-1:0]   saved_pc_i,
   input  logic [PC_W-1:0]   saved_npc_i,
   input  logic [47:0]       saved_state_i,
   input  logic [HPS_W-1:0]  saved_hstate_i,
   output logic [PC_W-1:0]   pc_o,
   output logic [PC_W-1:0]   npc_o,
   output logic [3:0]        xcc_o,
   output logic [3:0]        icc_o,
   output logic [7:0]        asi_o,
   output logic [11:0]       pstate_o,
   output logic [CWP_W-1:0]  cwp_o,
   output logic [2:0]        gl_o,
   output logic [HPS_W-1:0]  hpstate_o,
   output logic [TL_W-1:0]   tl_o,
   output logic              done_o,
   output logic              illegal_o
);
   if (NWIN < 2 || NWIN > 32) begin : g_bad_nwin
      $error("trap_return_unit: NWIN must lie in 2..32");
   end
   if (PC_W < 8) begin : g_bad_pcw
      $error("trap_return_unit: PC_W too small");
   end
   if (TL_W < 1) begin : g_bad_tlw
      $error("trap_return_unit: TL_W must be positive");
   end

   ts_fields_t          fld;
   logic [PC_W-1:0]     nxt_pc, nxt_npc;
   logic [CWP_W-1:0]    nxt_cwp;
   logic [GL_W-1:0]     nxt_gl;
   logic [HPS_W-1:0]    nxt_hps;
   logic                at_tl0;
   logic                unused_ts;

   assign fld       = split_ts(saved_state_i);
   assign at_tl0    = (cur_tl_i == '0);
   assign unused_ts = ^{saved_state_i[47:43], saved_state_i[23:20]};

   trp_pc_sel #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_pc_sel (
      .retry_i (cmd_retry_i),
      .tpc_i   (saved_pc_i),
      .tnpc_i  (saved_npc_i),
      .pc_o    (nxt_pc),
      .npc_o   (nxt_npc)
   );

   trp_cwp_map #(.NWIN(NWIN), .CWP_W(CWP_W)) u_cwp_map (
      .raw_i (fld.wraw),
      .cwp_o (nxt_cwp)
   );

   trp_hv_sel #(.HV_EN(HV_EN), .GL_W(GL_W), .HPS_W(HPS_W)) u_hv_sel (
      .cur_gl_i  (gl_o),
      .cur_hps_i (hpstate_o),
      .new_gl_i  (fld.gl),
      .new_hps_i (saved_hstate_i),
      .gl_o      (nxt_gl),
      .hps_o     (nxt_hps)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_o      <= '0;
         npc_o     <= '0;
         xcc_o     <= '0;
         icc_o     <= '0;
         asi_o     <= '0;
         pstate_o  <= '0;
         cwp_o     <= '0;
         gl_o      <= '0;
         hpstate_o <= '0;
         tl_o      <= '0;
         done_o    <= 1'b0;
         illegal_o <= 1'b0;
      end else begin
         done_o    <= 1'b0;
         illegal_o <= 1'b0;
         if (cmd_valid_i) begin
            if (at_tl0) begin
               illegal_o <= 1'b1;
            end else begin
               pc_o      <= nxt_pc;
               npc_o     <= nxt_npc;
               xcc_o     <= fld.xcc;
               icc_o     <= fld.icc;
               asi_o     <= fld.asi;
               pstate_o  <= fld.pst;
               cwp_o     <= nxt_cwp;
               gl_o      <= nxt_gl;
               hpstate_o <= nxt_hps;
               tl_o      <= cur_tl_i - TL_W'(1);
               done_o    <= 1'b1;
            end
         end
      end
   end

   // R2: done form resumes after the saved NPC
   p_done_npc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && !cmd_retry_i && cur_tl_i != '0) |=>
         (done_o && pc_o == $past(saved_npc_i)
          && npc_o == $past(saved_npc_i) + PC_W'(INSN_BYTES)));

   // R3: retry form resumes at the saved PC
   p_retry_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && cmd_retry_i && cur_tl_i != '0) |=>
         (done_o && pc_o == $past(saved_pc_i) && npc_o == $past(saved_npc_i)));

   // R9: trap level drops by one
   p_tl_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && cur_tl_i != '0) |=> (tl_o == $past(cur_tl_i) - TL_W'(1)));

   // R10: refused command leaves context untouched
   p_tl0_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && cur_tl_i == '0) |=>
         (illegal_o && !done_o && $stable(pc_o) && $stable(npc_o)
          && $stable(tl_o) && $stable(cwp_o) && $stable(pstate_o)));

   // R11: idle cycles hold everything
   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid_i |=>
         (!done_o && !illegal_o && $stable(pc_o) && $stable(npc_o)
          && $stable(tl_o) && $stable(gl_o) && $stable(asi_o)));

   // R7: window pointer stays inside the implemented range
   p_cwp_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cwp_o) < NWIN);

   // R6: masked-out processor-state bits never come back set
   p_pst_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pstate_o[7:6] == 2'b00);

   // R10: the two pulses are exclusive
   p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({done_o, illegal_o}) <= 1);
endmodule

// File: tb/trap_return_unit_tb.sv
module trap_return_unit_tb;
   localparam int PC_W  = 64;
   localparam int NWIN  = 8;
   localparam int TL_W  = 3;
   localparam int HPS_W = 12;
   localparam int CWP_W = $clog2(NWIN);

   typedef struct {
      logic [PC_W-1:0]  pc, npc;
      logic [3:0]       xcc, icc;
      logic [7:0]       asi;
      logic [11:0]      pst;
      logic [CWP_W-1:0] cwp;
      logic [2:0]       gl;
      logic [HPS_W-1:0] hps;
      logic [TL_W-1:0]  tl;
      logic             ill;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_retry = 1'b0;
   logic [TL_W-1:0]  cur_tl = '0;
   logic [PC_W-1:0]  s_pc = '0, s_npc = '0;
   logic [47:0]      s_ts = '0;
   logic [HPS_W-1:0] s_hs = '0;
   logic [PC_W-1:0]  pc, npc;
   logic [3:0]       xcc, icc;
   logic [7:0]       asi;
   logic [11:0]      pst;
   logic [CWP_W-1:0] cwp;
   logic [2:0]       gl;
   logic [HPS_W-1:0] hps;
   logic [TL_W-1:0]  tl;
   logic             done, illegal;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   exp_t sb[$];
   exp_t model;

   always #5 clk = ~clk;

   trap_return_unit #(.PC_W(PC_W), .NWIN(NWIN), .TL_W(TL_W), .HPS_W(HPS_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_retry_i(cmd_retry),
      .cur_tl_i(cur_tl), .saved_pc_i(s_pc), .saved_npc_i(s_npc),
      .saved_state_i(s_ts), .saved_hstate_i(s_hs),
      .pc_o(pc), .npc_o(npc), .xcc_o(xcc), .icc_o(icc), .asi_o(asi),
      .pstate_o(pst), .cwp_o(cwp), .gl_o(gl), .hpstate_o(hps), .tl_o(tl),
      .done_o(done), .illegal_o(illegal));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [47:0] mk_ts(input logic [2:0] g, input logic [7:0] ccr,
                                         input logic [7:0] a, input logic [11:0] p,
                                         input logic [7:0] w);
      return {5'b10101, g, ccr, a, 4'hF, p, w};
   endfunction

   // driver: drives one command for one cycle and pushes its expectation
   task automatic issue(input logic rty, input logic [TL_W-1:0] lvl,
                        input logic [PC_W-1:0] tpc, input logic [PC_W-1:0] tnpc,
                        input logic [47:0] ts, input logic [HPS_W-1:0] hs);
      exp_t e;
      if (lvl == '0) begin
         e = model;
         e.ill = 1'b1;
      end else begin
         e.pc  = rty ? tpc : tnpc;
         e.npc = rty ? tnpc : tnpc + 64'd4;
         e.xcc = ts[39:36];
         e.icc = ts[35:32];
         e.asi = ts[31:24];
         e.pst = ts[19:8] & 12'hF3F;
         e.cwp = CWP_W'(NWIN - 1 - (int'(ts[7:0]) % NWIN));
         e.gl  = ts[42:40];
         e.hps = hs;
         e.tl  = lvl - TL_W'(1);
         e.ill = 1'b0;
         model = e;
      end
      sb.push_back(e);
      cmd_valid = 1'b1; cmd_retry = rty; cur_tl = lvl;
      s_pc = tpc; s_npc = tnpc; s_ts = ts; s_hs = hs;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // monitor: pops expectation on each completion pulse
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && (done || illegal)) begin
            if (sb.size() == 0) begin
               chk("R11 unexpected pulse", {62'd0, done, illegal}, 64'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk("R10 illegal pulse", 64'(illegal), 64'(e.ill));
               chk("R10 done pulse", 64'(done), 64'(!e.ill));
               chk("R2/R3 pc", pc, e.pc);
               chk("R2/R3 npc", npc, e.npc);
               chk("R4 xcc", 64'(xcc), 64'(e.xcc));
               chk("R4 icc", 64'(icc), 64'(e.icc));
               chk("R5 asi", 64'(asi), 64'(e.asi));
               chk("R6 pstate", 64'(pst), 64'(e.pst));
               chk("R7 cwp", 64'(cwp), 64'(e.cwp));
               chk("R8 gl", 64'(gl), 64'(e.gl));
               chk("R8 hpstate", 64'(hps), 64'(e.hps));
               chk("R9 tl", 64'(tl), 64'(e.tl));
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model = '{pc: '0, npc: '0, xcc: '0, icc: '0, asi: '0, pst: '0,
                cwp: '0, gl: '0, hps: '0, tl: '0, ill: 1'b0};
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 pc", pc, 64'd0);
      chk("R1 tl", 64'(tl), 64'd0);
      chk("R1 cwp", 64'(cwp), 64'd0);
      chk("R1 pulses", {62'd0, done, illegal}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 done form, R6 mask of all-ones field, R7 raw 3 -> 4
      issue(1'b0, 3'd1, 64'h0FFC, 64'h1000, mk_ts(3'd5, 8'hA5, 8'h80, 12'hFFF, 8'd3), 12'h123);
      @(negedge clk);
      // R3 retry form, R7 raw 13 -> 2
      issue(1'b1, 3'd3, 64'h4000_0010, 64'h4000_0014, mk_ts(3'd7, 8'h3C, 8'h19, 12'h0C5, 8'd13), 12'hABC);
      // R11 back-to-back: R2 with NPC wrap, R7 raw 255 -> 0
      issue(1'b0, 3'd7, 64'h1234, 64'hFFFF_FFFF_FFFF_FFFC, mk_ts(3'd0, 8'hF0, 8'hFF, 12'h0C0, 8'd255), 12'h000);
      issue(1'b1, 3'd2, 64'hDEAD_BEE0, 64'hDEAD_BEE4, mk_ts(3'd2, 8'h0F, 8'h04, 12'h555, 8'd0), 12'hFFF);
      @(negedge clk);
      // R10 refused at trap level zero
      issue(1'b0, 3'd0, 64'h9999, 64'h8888, mk_ts(3'd6, 8'h77, 8'h66, 12'hAAA, 8'd5), 12'h777);
      @(negedge clk);
      // R11 idle: inputs wiggle with no strobe, outputs must hold
      s_pc = 64'h1; s_npc = 64'h2; s_ts = '1; cur_tl = 3'd4;
      repeat (3) @(negedge clk);
      chk("R11 hold pc", pc, model.pc);
      chk("R11 hold tl", 64'(tl), 64'(model.tl));
      chk("R11 hold gl", 64'(gl), 64'(model.gl));
      chk("R11 no pulse", {62'd0, done, illegal}, 64'd0);
      chk("R11 scoreboard drained", 64'(sb.size()), 64'd0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule